// File: doc/BRIEF.md
# Serial Flash Two-Step Software Reset Controller

This block sits on the device side of an SPI serial flash. It decodes 8-bit instruction frames and carries out a software reset, because the device has no dedicated reset pin. The reset needs two steps. An arm instruction (0x66) must be followed directly by a commit instruction (0x99). Any other complete instruction between the two cancels the arming. When the commit is accepted, the block does three things: it issues a one-cycle clear pulse that stops internal operations, it returns the volatile state registers it holds to their power-on values, and it starts a busy lockout. During the lockout every incoming instruction is ignored.

The SPI pins are sampled by the system clock through synchronizers, and a bit is taken on each rising SCK edge. A frame counts only if chip select rises after exactly eight clock edges. The volatile state has an update port that stands for the rest of the device: write-enable latch, suspend flag, volatile status bits, read parameter byte, continuous-read mode byte and wrap bits. The lockout length is a parameter given in system clock cycles. For example, 30 us at 100 MHz is 3000 cycles.

Top module: `sfr_soft_reset`

## Requirements
- R1: After rst_ni is released: armed_o=0, busy_o=0, clr_o=0, wel_o=0, sus_o=0, vstat_o=VSTAT_RST, rdpar_o=0x00, cmode_o=0x00, wrap_o=3'b111.
- R2: An accepted 0x66 frame sets armed_o and changes nothing else. The state outputs keep their values and busy_o stays low.
- R3: An accepted 0x99 frame while armed_o is high does four things: it raises clr_o for exactly one cycle, clears armed_o, raises busy_o, and returns every state output to the R1 values.
- R4: Any accepted frame other than 0x99 or 0x66 received while armed clears armed_o without a reset. A repeated 0x66 keeps the block armed.
- R5: An accepted 0x99 frame while not armed is ignored. No clr_o, no busy_o, the state is unchanged and armed_o stays 0.
- R6: A frame is accepted only if chip select rises after exactly 8 rising SCK edges. Frames with fewer or more edges leave armed_o, busy_o and the state unchanged.
- R7: busy_o stays high for exactly LOCK_CYCLES clock cycles from the cycle in which clr_o is high. While it is high, frames and state writes are ignored.
- R8: Frames are taken correctly both with SCK idling low (mode 0) and with SCK idling high (mode 3), MSB first, each bit sampled on the rising SCK edge.
- R9: sdo_oe_o is 0 at all times, so the data output stays high-impedance.
- R10: When busy_o is low, st_we_i loads the state outputs from the matching inputs on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI serial clock |
| cs_ni | input | 1 | SPI chip select, active low |
| sdi_i | input | 1 | SPI serial data in |
| sdo_oe_o | output | 1 | Data-out drive enable, always 0 |
| st_we_i | input | 1 | Volatile state write strobe |
| wel_i | input | 1 | Write-enable latch value to load |
| sus_i | input | 1 | Suspend flag value to load |
| vstat_i | input | VSTAT_W | Volatile status bits to load |
| rdpar_i | input | 8 | Read parameter byte to load |
| cmode_i | input | 8 | Continuous-read mode byte to load |
| wrap_i | input | 3 | Wrap bits to load |
| armed_o | output | 1 | Reset armed |
| busy_o | output | 1 | Reset lockout in progress |
| clr_o | output | 1 | One-cycle reset/abort pulse |
| wel_o | output | 1 | Write-enable latch |
| sus_o | output | 1 | Suspend flag |
| vstat_o | output | VSTAT_W | Volatile status bits |
| rdpar_o | output | 8 | Read parameter byte |
| cmode_o | output | 8 | Continuous-read mode byte |
| wrap_o | output | 3 | Wrap bits |

## Verification
The bench arms the block and then sends every one of the 256 opcodes in alternating SPI modes. This catches a decoder that lets some stray opcode keep the arming, or that resets without the arm step. Frames one bit short and one bit long are sent both while armed and while unarmed; a design that miscounted edges would commit or disarm on them. It also sends a 0x66 instruction and a state write in the middle of the lockout: a design that leaked commands through the lockout would arm or let the write through. The bench measures the exact busy width and counts clear pulses, so a lockout off by one cycle or a repeated pulse shows up at once.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned OP_W = 8;
  localparam logic [OP_W-1:0] OP_ARM    = 8'h66;
  localparam logic [OP_W-1:0] OP_COMMIT = 8'h99;
  localparam logic [2:0] WRAP_RST  = 3'b111;
  localparam logic [7:0] RDPAR_RST = 8'h00;
  localparam logic [7:0] CMODE_RST = 8'h00;

  typedef struct packed {
    logic       wel;
    logic       sus;
    logic [2:0] wrap;
    logic [7:0] rdpar;
    logic [7:0] cmode;
  } fixed_state_t;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stg
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg[s] <= RST_VAL;
          else         stg[s] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg[s] <= RST_VAL;
          else         stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sfr_spi_rx.sv
module sfr_spi_rx
  import sfr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sck_i,
  input  logic            cs_ni,
  input  logic            sdi_i,
  output logic            frame_vld_o,
  output logic [OP_W-1:0] frame_byte_o
);
  localparam int unsigned CNT_OVF = OP_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_OVF + 1);

  logic [2:0] raw, syn;
  logic sck_s, cs_s, sdi_s;
  logic sck_d, cs_d;
  logic [CNT_W-1:0] bit_cnt;
  logic [OP_W-1:0]  shreg;
  logic sck_rise, cs_rise;

  assign raw = {sck_i, cs_ni, sdi_i};

  sfr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {sck_s, cs_s, sdi_s} = syn;
  assign sck_rise = sck_s & ~sck_d & ~cs_s;
  assign cs_rise  = cs_s & ~cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  // counter saturates one past a full byte so long frames stay rejected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      bit_cnt <= '0;
    else if (cs_s)                                    bit_cnt <= '0;
    else if (sck_rise && bit_cnt != CNT_W'(CNT_OVF))  bit_cnt <= bit_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shreg <= '0;
    else if (sck_rise) shreg <= {shreg[OP_W-2:0], sdi_s};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_vld_o  <= 1'b0;
      frame_byte_o <= '0;
    end else begin
      frame_vld_o  <= cs_rise && (bit_cnt == CNT_W'(OP_W));
      frame_byte_o <= shreg;
    end
  end

  p_cnt_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(CNT_OVF));

  p_frame_cnt_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |-> (bit_cnt == '0));

  p_frame_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |=> !frame_vld_o);
endmodule

// File: rtl/sfr_reset_fsm.sv
module sfr_reset_fsm
  import sfr_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 3000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_vld_i,
  input  logic [OP_W-1:0] frame_byte_i,
  output logic            armed_o,
  output logic            busy_o,
  output logic            clr_o
);
  localparam int unsigned LCK_W = $clog2(LOCK_CYCLES + 1);

  logic [LCK_W-1:0] lock_cnt;
  logic accept, commit;

  assign busy_o = (lock_cnt != '0);
  assign accept = frame_vld_i & ~busy_o;
  assign commit = accept & armed_o & (frame_byte_i == OP_COMMIT);

  // every accepted frame rewrites the armed flag: only the arm opcode sets it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_o <= 1'b0;
    else if (accept) armed_o <= (frame_byte_i == OP_ARM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_cnt <= '0;
    else if (commit)    lock_cnt <= LCK_W'(LOCK_CYCLES);
    else if (busy_o)    lock_cnt <= lock_cnt - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_o <= 1'b0;
    else         clr_o <= commit;
  end

  p_busy_disarmed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !armed_o);

  p_clr_with_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> busy_o);

  p_clr_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o);

  p_busy_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> clr_o);

  p_commit_armed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> $past(armed_o));

  p_busy_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_cnt > LCK_W'(1)) |=> busy_o);
endmodule

// File: rtl/sfr_vol_regs.sv
module sfr_vol_regs
  import sfr_pkg::*;
#(
  parameter int unsigned        VSTAT_W   = 8,
  parameter logic [VSTAT_W-1:0] VSTAT_RST = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               block_i,
  input  logic               we_i,
  input  fixed_state_t       fix_i,
  input  logic [VSTAT_W-1:0] vstat_i,
  output fixed_state_t       fix_o,
  output logic [VSTAT_W-1:0] vstat_o
);
  localparam fixed_state_t FIX_RST = '{
    wel: 1'b0, sus: 1'b0, wrap: WRAP_RST, rdpar: RDPAR_RST, cmode: CMODE_RST};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fix_o   <= FIX_RST;
      vstat_o <= VSTAT_RST;
    end else if (clr_i) begin
      fix_o   <= FIX_RST;
      vstat_o <= VSTAT_RST;
    end else if (we_i && !block_i) begin
      fix_o   <= fix_i;
      vstat_o <= vstat_i;
    end
  end

  p_clr_default_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (fix_o == FIX_RST) && (vstat_o == VSTAT_RST));

  p_wr_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_i && !clr_i) |=> $stable(fix_o) && $stable(vstat_o));
endmodule

// File: rtl/sfr_soft_reset.sv
module sfr_soft_reset
  import sfr_pkg::*;
#(
  parameter int unsigned        VSTAT_W     = 8,
  parameter logic [VSTAT_W-1:0] VSTAT_RST   = '0,
  parameter int unsigned        LOCK_CYCLES = 3000,
  parameter int unsigned        SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               cs_ni,
  input  logic               sdi_i,
  output logic               sdo_oe_o,
  input  logic               st_we_i,
  input  logic               wel_i,
  input  logic               sus_i,
  input  logic [VSTAT_W-1:0] vstat_i,
  input  logic [7:0]         rdpar_i,
  input  logic [7:0]         cmode_i,
  input  logic [2:0]         wrap_i,
  output logic               armed_o,
  output logic               busy_o,
  output logic               clr_o,
  output logic               wel_o,
  output logic               sus_o,
  output logic [VSTAT_W-1:0] vstat_o,
  output logic [7:0]         rdpar_o,
  output logic [7:0]         cmode_o,
  output logic [2:0]         wrap_o
);
  logic            frame_vld;
  logic [OP_W-1:0] frame_byte;
  fixed_state_t    fix_in, fix_q;

  // both reset instructions are input-only
  assign sdo_oe_o = 1'b0;

  assign fix_in = '{wel: wel_i, sus: sus_i, wrap: wrap_i, rdpar: rdpar_i, cmode: cmode_i};
  assign wel_o   = fix_q.wel;
  assign sus_o   = fix_q.sus;
  assign wrap_o  = fix_q.wrap;
  assign rdpar_o = fix_q.rdpar;
  assign cmode_o = fix_q.cmode;

  sfr_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sck_i       (sck_i),
    .cs_ni       (cs_ni),
    .sdi_i       (sdi_i),
    .frame_vld_o (frame_vld),
    .frame_byte_o(frame_byte)
  );

  sfr_reset_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_vld_i (frame_vld),
    .frame_byte_i(frame_byte),
    .armed_o     (armed_o),
    .busy_o      (busy_o),
    .clr_o       (clr_o)
  );

  sfr_vol_regs #(.VSTAT_W(VSTAT_W), .VSTAT_RST(VSTAT_RST)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_o),
    .block_i(busy_o),
    .we_i   (st_we_i),
    .fix_i  (fix_in),
    .vstat_i(vstat_i),
    .fix_o  (fix_q),
    .vstat_o(vstat_o)
  );

  p_oe_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o);
endmodule

// File: tb/sim_sfr_soft_reset.sv
`timescale 1ns/1ps
module sim_sfr_soft_reset;
  localparam int unsigned VW   = 4;
  localparam logic [VW-1:0] VRST = 4'hA;
  localparam int unsigned LOCK = 200;
  localparam int unsigned HP   = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic we = 1'b0, wel_in = 1'b0, sus_in = 1'b0;
  logic [VW-1:0] vst_in = '0;
  logic [7:0] rdp_in = '0, cmd_in = '0;
  logic [2:0] wrp_in = '0;
  logic sdo_oe, armed, busy, clr, wel, sus;
  logic [VW-1:0] vst;
  logic [7:0] rdp, cmd;
  logic [2:0] wrp;

  int checks = 0, errors = 0;
  int run = 0, last_w = 0, clr_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sfr_soft_reset #(.VSTAT_W(VW), .VSTAT_RST(VRST), .LOCK_CYCLES(LOCK)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .sdi_i(sdi),
    .sdo_oe_o(sdo_oe), .st_we_i(we), .wel_i(wel_in), .sus_i(sus_in),
    .vstat_i(vst_in), .rdpar_i(rdp_in), .cmode_i(cmd_in), .wrap_i(wrp_in),
    .armed_o(armed), .busy_o(busy), .clr_o(clr), .wel_o(wel), .sus_o(sus),
    .vstat_o(vst), .rdpar_o(rdp), .cmode_o(cmd), .wrap_o(wrp));

  // {wel,sus,vstat,rdpar,cmode,wrap}
  localparam logic [24:0] DEF = {1'b0, 1'b0, VRST, 8'h00, 8'h00, 3'b111};
  localparam logic [24:0] PAT = {1'b1, 1'b1, 4'h5, 8'h3C, 8'hA5, 3'b010};

  function automatic logic [24:0] st();
    return {wel, sus, vst, rdp, cmd, wrp};
  endfunction

  always @(negedge clk) begin
    if (busy) run++;
    else if (run != 0) begin last_w = run; run = 0; end
    if (clr) clr_cnt++;
    if (sdo_oe !== 1'b0) begin
      checks++; errors++;
      $display("FAIL R9: sdo_oe actual %0h expected 0", sdo_oe);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] bits, input int n, input bit m3);
    @(negedge clk);
    sck = m3;
    wait_clk(HP);
    cs_n = 1'b0;
    wait_clk(HP);
    for (int i = n - 1; i >= 0; i--) begin
      sck = 1'b0;
      sdi = bits[i];
      wait_clk(HP);
      sck = 1'b1;
      wait_clk(HP);
    end
    if (!m3) sck = 1'b0;
    wait_clk(HP);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic write_st(input logic [24:0] v);
    @(negedge clk);
    {wel_in, sus_in, vst_in, rdp_in, cmd_in, wrp_in} = v;
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    wait_clk(1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    wait_clk(2);
  endtask

  initial begin
    int c0;
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);
    // R1 reset state
    chk("R1 armed", armed, 0);
    chk("R1 busy", busy, 0);
    chk("R1 clr", clr, 0);
    chk("R1 state", st(), DEF);
    chk("R9 oe", sdo_oe, 0);

    write_st(PAT);
    chk("R10 write", st(), PAT);

    // R5 commit without arm
    send(16'h99, 8, 0);
    chk("R5 armed", armed, 0);
    chk("R5 busy", busy, 0);
    chk("R5 state", st(), PAT);
    chk("R5 clr", clr_cnt, 0);

    // R2 arm only
    send(16'h66, 8, 0);
    chk("R2 armed", armed, 1);
    chk("R2 busy", busy, 0);
    chk("R2 state", st(), PAT);

    // R3 commit, R7 lockout
    c0 = clr_cnt;
    send(16'h99, 8, 0);
    chk("R3 busy", busy, 1);
    chk("R3 armed", armed, 0);
    chk("R3 state", st(), DEF);
    chk("R3 pulse", clr_cnt - c0, 1);
    send(16'h66, 8, 1);
    chk("R7 arm ignored", armed, 0);
    write_st(PAT);
    chk("R7 write ignored", st(), DEF);
    chk("R7 still busy", busy, 1);
    wait_idle();
    chk("R7 width", last_w, LOCK);
    chk("R7 arm after", armed, 0);
    write_st(PAT);
    chk("R10 write after", st(), PAT);

    // R6 short/long frames
    send(16'h66, 8, 0);
    send(16'h33, 7, 0);
    chk("R6 short keeps arm", armed, 1);
    send(16'h199, 9, 1);
    chk("R6 long keeps arm", armed, 1);
    chk("R6 long no busy", busy, 0);
    chk("R6 long state", st(), PAT);
    send(16'h4C, 7, 0);
    chk("R6 short no commit", busy, 0);
    c0 = clr_cnt;
    send(16'h99, 8, 1);
    chk("R8 mode3 commit", busy, 1);
    chk("R6 commit after", st(), DEF);
    chk("R3 pulse 2", clr_cnt - c0, 1);
    wait_idle();
    chk("R7 width 2", last_w, LOCK);
    send(16'h166, 9, 0);
    chk("R6 long no arm", armed, 0);
    send(16'h0CC, 7, 1);
    chk("R6 short no arm", armed, 0);
    write_st(PAT);

    // R8 mode 3 arm
    send(16'h66, 8, 1);
    chk("R8 mode3 arm", armed, 1);

    // R4 sweep of intervening opcodes
    for (int b = 0; b < 256; b++) begin
      bit m3;
      m3 = b[0];
      send(16'h66, 8, m3);
      send(16'(b), 8, ~m3);
      chk("R4 armed after op", armed, (b == 8'h66) ? 1 : 0);
      if (b == 8'h99) begin
        chk("R3 sweep busy", busy, 1);
        chk("R3 sweep state", st(), DEF);
        wait_idle();
        write_st(PAT);
      end else begin
        send(16'h99, 8, m3);
        chk("R4 commit gated", busy, (b == 8'h66) ? 1 : 0);
        chk("R4 state", st(), (b == 8'h66) ? DEF : PAT);
        if (b == 8'h66) begin
          wait_idle();
          write_st(PAT);
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule